// File: doc/BRIEF.md
# Dual-Rate Token Bucket Shaper

This block limits the traffic that leaves one node of a transmit scheduler. It keeps two credit pools, in bytes. The committed pool follows a guaranteed rate. The peak pool follows an upper rate. A request carrying a packet length is let through only while the peak pool can cover that length.

Each accepted packet is charged against both pools. The committed pool may go into debt, down to a floor of minus one maximum-size packet. An accepted packet is marked as excess when the committed pool could not cover it.

Each pool is programmed with its own configuration word. The rate is a mantissa `rate_b`, scaled by `2^rate_u`, and that amount of credit is delivered once every `2^rate_s` ticks. The burst depth is `burst_b` scaled by `2^burst_s`. The tick length is set by the level of the node in the scheduling hierarchy. It is counted in cycles of the 1 GHz reference clock that drives the block.

Top module: `dual_rate_shaper`

## Requirements
- R1: A tick is TICK cycles long. TICK is 1536 for NODE_LEVEL 0 (priority) and NODE_LEVEL 3 (queue set), 192 for NODE_LEVEL 1 (group) and 48 for NODE_LEVEL 2 (port). The first tick ends TICK cycles after reset is released. Credit only arrives at the clock edge that ends a tick, and a pool is never refilled between ticks.
- R2: `cfg_word` holds the following fields:
  - bits [7:0]: `rate_b`
  - bits [11:8]: `rate_u`
  - bits [15:12]: `rate_s`
  - bits [23:16]: `burst_b`
  - bits [28:24]: `burst_s`

  A write with `cfg_sel`=1 targets the peak pool. A write with `cfg_sel`=0 targets the committed pool.
- R3: Every `2^rate_s` ticks, counted from the tick at which the word took effect, a pool gains `rate_b * 2^rate_u` bytes. The gain lands at the edge that ends the last of those ticks.
- R4: A pool never holds more than `burst_b * 2^burst_s` bytes. Any credit above that depth is discarded.
- R5: `req_ready` is 1 exactly when the peak pool, including any refill landing at the end of the current cycle, holds at least `req_len` bytes. `req_ready` does not depend on `req_valid`. A packet is accepted in a cycle where `req_valid` and `req_ready` are both 1.
- R6: On acceptance, `req_len` is subtracted once from each pool. The peak pool never goes below zero.
- R7: `req_excess` is 1 when the committed pool, including any refill at the end of the current cycle, holds fewer than `req_len` bytes. Committed debt is clamped at a floor of -MAX_PKT.
- R8: A pool whose `rate_b` is 0 never gains credit and is never charged. As the peak pool, it never drops `req_ready`. As the committed pool, it never raises `req_excess`.
- R9: A configuration write takes effect at the edge ending the first tick that is not earlier than the write. Until then the old word governs. When the new word takes effect, the pool's refill-period count restarts and its content is clamped to the new depth.
- R10: After reset, both pools use the words DEF_CMT_WORD and DEF_PEAK_WORD and are filled to their full depth. By default `rate_b` is 0, `burst_b` is 5 and `burst_s` is 20.
- R11: Back-pressure rule: once the source raises `req_valid`, it holds `req_valid` high and `req_len` unchanged until it sees `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 GHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Pool select: 1 peak, 0 committed |
| cfg_word | input | 29 | Packed rate and burst fields |
| req_valid | input | 1 | A packet request is present |
| req_len | input | LEN_W | Packet length in bytes |
| req_ready | output | 1 | The packet conforms and may be sent |
| req_excess | output | 1 | The packet exceeds the committed rate |

## Verification
The assertions take for granted that the source obeys the rule in R11. The bench keeps to this: whenever it tests a hold decision without waiting for the pool to refill, it leaves `req_valid` low. A held request is driven only in the one scenario that waits for the refill with length and valid frozen.

The depth and growth properties also assume that no pool gains credit except at a tick boundary. The same properties allow a pool to stay above a freshly lowered depth for exactly one cycle.

// File: rtl/shp_pkg.sv
package shp_pkg;

  localparam int RATE_B_W  = 8;
  localparam int RATE_U_W  = 4;
  localparam int RATE_S_W  = 4;
  localparam int BURST_B_W = 8;
  localparam int BURST_S_W = 5;

  // Bit 0 of the word is the least significant bit of rate_b.
  typedef struct packed {
    logic [BURST_S_W-1:0] burst_s;
    logic [BURST_B_W-1:0] burst_b;
    logic [RATE_S_W-1:0]  rate_s;
    logic [RATE_U_W-1:0]  rate_u;
    logic [RATE_B_W-1:0]  rate_b;
  } shp_cfg_t;

  localparam int CFG_W = $bits(shp_cfg_t);

  // Tick length in reference cycles for each hierarchy level.
  function automatic int tick_cycles(input int level);
    case (level)
      0:       return 1536;
      1:       return 192;
      2:       return 48;
      3:       return 1536;
      default: return 48;
    endcase
  endfunction

endpackage

// File: rtl/shp_tick_gen.sv
module shp_tick_gen #(
  parameter int TICK = 48
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (TICK > 1) ? $clog2(TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/shp_bucket.sv
module shp_bucket
  import shp_pkg::*;
#(
  parameter int       FILL_W     = 44,
  parameter int       LEN_W      = 16,
  parameter int       MAX_PKT    = 1536,
  parameter bit       ALLOW_DEBT = 1'b0,
  parameter shp_cfg_t DEF_CFG    = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_i,
  input  logic                     wr_i,
  input  shp_cfg_t                 cfg_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic                     take_i,
  output logic                     ok_o,
  output logic                     exempt_o,
  output logic signed [FILL_W-1:0] fill_o,
  output logic signed [FILL_W-1:0] depth_o
);
  localparam int PC_W = 1 << RATE_S_W;
  localparam logic signed [FILL_W-1:0] RST_DEPTH =
    $signed(FILL_W'(DEF_CFG.burst_b) << DEF_CFG.burst_s);
  localparam logic signed [FILL_W-1:0] FLOOR = -$signed(FILL_W'(MAX_PKT));

  shp_cfg_t                  act_q, pend_q;
  logic                      pend_v_q;
  logic [PC_W-1:0]           per_q, per_last;
  logic                      refill, load, exempt;
  logic signed [FILL_W-1:0]  fill_q, depth, gain, sum, lim, len_s, after, debit_val, nxt;

  assign exempt   = (act_q.rate_b == '0);
  assign per_last = (PC_W'(1) << act_q.rate_s) - PC_W'(1);
  assign refill   = tick_i && (per_q == per_last);
  assign load     = tick_i && (wr_i || pend_v_q);

  assign depth = $signed(FILL_W'(act_q.burst_b) << act_q.burst_s);
  assign gain  = (refill && !exempt) ? $signed(FILL_W'(act_q.rate_b) << act_q.rate_u) : '0;
  assign sum   = fill_q + gain;
  assign lim   = (sum > depth) ? depth : sum;
  assign len_s = $signed(FILL_W'(len_i));
  assign after = lim - len_s;

  generate
    if (ALLOW_DEBT) begin : g_debt
      assign debit_val = (after < FLOOR) ? FLOOR : after;
    end else begin : g_nodebt
      assign debit_val = (after < 0) ? '0 : after;
    end
  endgenerate

  assign nxt = (take_i && !exempt) ? debit_val : lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= DEF_CFG;
      pend_q   <= DEF_CFG;
      pend_v_q <= 1'b0;
      per_q    <= '0;
      fill_q   <= RST_DEPTH;
    end else begin
      fill_q <= nxt;
      if (tick_i) begin
        pend_v_q <= 1'b0;
        if (load) begin
          act_q <= wr_i ? cfg_i : pend_q;
          per_q <= '0;
        end else if (refill) begin
          per_q <= '0;
        end else begin
          per_q <= per_q + 1'b1;
        end
      end else if (wr_i) begin
        pend_q   <= cfg_i;
        pend_v_q <= 1'b1;
      end
    end
  end

  assign ok_o     = exempt || (lim >= len_s);
  assign exempt_o = exempt;
  assign fill_o   = fill_q;
  assign depth_o  = depth;
endmodule

// File: rtl/dual_rate_shaper.sv
module dual_rate_shaper
  import shp_pkg::*;
#(
  parameter int               NODE_LEVEL    = 2,
  parameter int               LEN_W         = 16,
  parameter int               MAX_PKT       = 1536,
  parameter int               FILL_W        = 44,
  parameter logic [CFG_W-1:0] DEF_CMT_WORD  = {5'd20, 8'd5, 4'd0, 4'd0, 8'd0},
  parameter logic [CFG_W-1:0] DEF_PEAK_WORD = {5'd20, 8'd5, 4'd0, 4'd0, 8'd0}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             req_excess
);
  localparam int TICK     = tick_cycles(NODE_LEVEL);
  localparam int N_BKT    = 2;
  localparam int BKT_CMT  = 0;
  localparam int BKT_PEAK = 1;

  logic                     tick_w;
  logic                     accept;
  logic                     bkt_ok     [N_BKT];
  logic                     bkt_exempt [N_BKT];
  logic signed [FILL_W-1:0] bkt_fill   [N_BKT];
  logic signed [FILL_W-1:0] bkt_depth  [N_BKT];

  logic signed [FILL_W-1:0] pk_fill, pk_depth, cm_fill, cm_depth;
  logic                     pk_zero, cm_zero;

  shp_tick_gen #(.TICK(TICK)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick_w)
  );

  assign accept = req_valid && req_ready;

  generate
    for (genvar gi = 0; gi < N_BKT; gi++) begin : g_bkt
      localparam shp_cfg_t DEF = (gi == BKT_CMT) ? shp_cfg_t'(DEF_CMT_WORD)
                                                 : shp_cfg_t'(DEF_PEAK_WORD);
      shp_bucket #(
        .FILL_W     (FILL_W),
        .LEN_W      (LEN_W),
        .MAX_PKT    (MAX_PKT),
        .ALLOW_DEBT (gi == BKT_CMT),
        .DEF_CFG    (DEF)
      ) u_bkt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_w),
        .wr_i     (cfg_wr && (cfg_sel == 1'(gi))),
        .cfg_i    (shp_cfg_t'(cfg_word)),
        .len_i    (req_len),
        .take_i   (accept),
        .ok_o     (bkt_ok[gi]),
        .exempt_o (bkt_exempt[gi]),
        .fill_o   (bkt_fill[gi]),
        .depth_o  (bkt_depth[gi])
      );
    end
  endgenerate

  assign req_ready  = bkt_ok[BKT_PEAK];
  assign req_excess = !bkt_ok[BKT_CMT];

  assign pk_fill  = bkt_fill[BKT_PEAK];
  assign pk_depth = bkt_depth[BKT_PEAK];
  assign pk_zero  = bkt_exempt[BKT_PEAK];
  assign cm_fill  = bkt_fill[BKT_CMT];
  assign cm_depth = bkt_depth[BKT_CMT];
  assign cm_zero  = bkt_exempt[BKT_CMT];
endmodule

// File: rtl/shp_checker.sv
module shp_checker #(
  parameter int FILL_W  = 44,
  parameter int LEN_W   = 16,
  parameter int MAX_PKT = 1536
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_excess,
  input logic [LEN_W-1:0]         req_len,
  input logic signed [FILL_W-1:0] pk_fill,
  input logic signed [FILL_W-1:0] pk_depth,
  input logic                     pk_zero,
  input logic signed [FILL_W-1:0] cm_fill,
  input logic signed [FILL_W-1:0] cm_depth,
  input logic                     cm_zero
);
  localparam logic signed [FILL_W-1:0] FLOOR = -$signed(FILL_W'(MAX_PKT));

  a_r6_peak_nonneg: assert property (@(posedge clk) disable iff (rst)
    pk_fill >= 0);

  a_r7_debt_floor: assert property (@(posedge clk) disable iff (rst)
    cm_fill >= FLOOR);

  a_r4_peak_depth: assert property (@(posedge clk) disable iff (rst)
    (pk_fill > pk_depth) |-> $past(tick));

  a_r4_cmt_depth: assert property (@(posedge clk) disable iff (rst)
    (cm_fill > cm_depth) |-> $past(tick));

  a_r3_peak_gain_on_tick: assert property (@(posedge clk) disable iff (rst)
    (pk_fill > $past(pk_fill)) |-> $past(tick));

  a_r1_cmt_gain_on_tick: assert property (@(posedge clk) disable iff (rst)
    (cm_fill > $past(cm_fill)) |-> $past(tick));

  a_r8_peak_zero_open: assert property (@(posedge clk) disable iff (rst)
    pk_zero |-> req_ready);

  a_r8_cmt_zero_clean: assert property (@(posedge clk) disable iff (rst)
    cm_zero |-> !req_excess);

  a_r11_len_held: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_len)));
endmodule

bind dual_rate_shaper shp_checker #(
  .FILL_W  (FILL_W),
  .LEN_W   (LEN_W),
  .MAX_PKT (MAX_PKT)
) u_shp_checker (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick_w),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_excess (req_excess),
  .req_len    (req_len),
  .pk_fill    (pk_fill),
  .pk_depth   (pk_depth),
  .pk_zero    (pk_zero),
  .cm_fill    (cm_fill),
  .cm_depth   (cm_depth),
  .cm_zero    (cm_zero)
);

// File: tb/test_dual_rate_shaper.sv
module test_dual_rate_shaper;
  localparam int LEN_W = 16;
  localparam int TICK  = 48;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_wr = 1'b0;
  logic             cfg_sel = 1'b0;
  logic [28:0]      cfg_word = '0;
  logic             req_valid = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_ready, req_excess;

  int n_chk  = 0;
  int n_fail = 0;
  int bph;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Tick phase model (R1): ticks end every TICK cycles after reset release.
  always_ff @(posedge clk) begin
    if (rst) bph <= 0;
    else     bph <= (bph == TICK - 1) ? 0 : bph + 1;
  end

  dual_rate_shaper i_dual_rate_shaper (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_word   (cfg_word),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .req_ready  (req_ready),
    .req_excess (req_excess)
  );

  function automatic logic [28:0] mk(input int rb, input int ru, input int rs,
                                     input int bb, input int bs);
    return {5'(bs), 8'(bb), 4'(rs), 4'(ru), 8'(rb)};
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_at(input int v);
    do @(negedge clk); while (bph != v);
  endtask

  task automatic probe(input int len, input int exp_rdy, input int exp_exc, input string tag);
    req_valid = 1'b0;
    req_len   = LEN_W'(len);
    #1;
    if (exp_rdy >= 0) chk({tag, " ready"}, req_ready, exp_rdy);
    if (exp_exc >= 0) chk({tag, " excess"}, req_excess, exp_exc);
    @(negedge clk);
  endtask

  task automatic send(input int len, input int exp_exc, input string tag);
    req_valid = 1'b1;
    req_len   = LEN_W'(len);
    #1;
    chk({tag, " accept ready"}, req_ready, 1);
    if (exp_exc >= 0) chk({tag, " accept excess"}, req_excess, exp_exc);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg(input logic sel, input logic [28:0] w);
    cfg_wr   = 1'b1;
    cfg_sel  = sel;
    cfg_word = w;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  task automatic t_reset;
    probe(1536, 1, 0, "R10 reset pools open");
  endtask

  task automatic t_conform;
    wait_at(5);
    cfg(1'b1, mk(10, 0, 0, 1, 6));   // R2 peak: 10 B per tick, depth 64
    cfg(1'b0, mk(5, 0, 0, 1, 5));    // R2 committed: 5 B per tick, depth 32
    wait_at(0);
    wait_at(0);
    wait_at(5);
    probe(65, 0, -1, "R4 peak depth");
    probe(64, 1, -1, "R4 peak full");
    probe(33, 1, 1, "R7 committed short");
    probe(32, 1, 0, "R7 committed covers");
    send(40, 1, "R5");               // peak 24, committed -8
    probe(25, 0, -1, "R6 peak debited");
    probe(24, 1, 1, "R6 committed debited");
    send(24, 1, "R5 drain");         // peak 0, committed -32
    // R11: hold a request until the next refill
    req_valid = 1'b1;
    req_len   = 16'd10;
    for (int c = bph; c < TICK - 1; c++) begin
      #1;
      chk("R11 held no credit between ticks R1", req_ready, 0);
      @(negedge clk);
    end
    #1;
    chk("R1 refill at tick end R3", req_ready, 1);
    chk("R7 excess with debt", req_excess, 1);
    @(negedge clk);
    req_valid = 1'b0;
    probe(1, 0, 1, "R6 single debit");
  endtask

  task automatic t_period;
    wait_at(0);
    wait_at(0);
    wait_at(0);
    wait_at(5);
    cfg(1'b1, mk(8, 1, 2, 16, 0));   // 16 B every 4 ticks, depth 16
    cfg(1'b0, mk(0, 0, 0, 1, 6));    // committed disabled
    wait_at(0);
    wait_at(5);
    send(16, 0, "R9 clamp R8");
    probe(1, 0, 0, "R3 empty");
    for (int k = 1; k <= 3; k++) begin
      wait_at(TICK - 1);
      probe(1, 0, -1, "R3 exponent period");
    end
    wait_at(TICK - 1);
    probe(17, 0, -1, "R3 scaled gain bound");
    probe(16, 1, -1, "R3 scaled gain");
    probe(1536, 0, 0, "R8 committed never excess");
  endtask

  task automatic t_update;
    wait_at(5);
    cfg(1'b1, mk(0, 0, 0, 1, 6));
    probe(100, 0, -1, "R9 pending");
    wait_at(TICK - 1);
    probe(100, 0, -1, "R9 old word until boundary");
    probe(1536, 1, 0, "R9 applied R8");
  endtask

  task automatic t_floor;
    cfg(1'b0, mk(100, 0, 0, 100, 0));
    wait_at(0);
    wait_at(2);
    for (int p = 0; p < 20; p++) send(1000, -1, "R8 peak never blocks");
    probe(1000, 1, 1, "R7 deep debt");
    for (int t = 0; t < 15; t++) wait_at(0);
    probe(64, 1, 1, "R7 floor partial");
    wait_at(0);
    probe(64, 1, 0, "R7 floor recovered");
    probe(65, 1, 1, "R7 floor exact");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_conform();
    t_period();
    t_update();
    t_floor();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule